// File: doc/BRIEF.md
# Banked Scratchpad Conflict Serializer

This block is the read front end of a 16-bank scratchpad whose banks are 32 bits wide. A group of 16 threads presents one request: an active bit and a word address per thread. The block sorts the active threads by bank and reads the banks in as many passes as the worst bank needs. It returns one data word per thread, together with the number of bank passes the request took.

A bank can deliver only one word per pass. Two threads that want different words in one bank are therefore served in different passes. Threads that want the very same word are served together by one broadcast read. In every pass, each bank serves the word wanted by its lowest-numbered thread that is still waiting, and every other waiting thread that wants that same word is served with it.

The storage sits inside the block as one synchronous RAM per bank. Each RAM is loaded at start-up with a fixed, computed pattern, so a reader can predict every word.

Top module: `scratch_conflict_serializer`

## Requirements
- R1: Word address `a` lies in bank `a mod 16`. The 10-bit address of thread `t` is `req_addr[t*10 +: 10]`. The word that thread `t` receives is `rsp_data[t*32 +: 32]`, and it equals the stored word at `a`. The stored word at `a` is `(a * 32'h9E3779B1) ^ 32'h5A5A0000`, computed in 32-bit arithmetic.
- R2: A request is taken on a clock edge where `req_valid` and `req_ready` are both high. `req_ready` is high only while the block is idle. It goes low on the edge after a request is taken and comes back high together with `rsp_valid`.
- R3: When every active thread uses a different bank, `rsp_cycles` is 1.
- R4: Any number of active threads that read the same word count as a single access. A request in which all 16 threads read one word gives `rsp_cycles` = 1.
- R5: `rsp_cycles` equals the largest number of distinct words that active threads ask for in any one bank. A stride of 2 words gives 2, a stride of 8 words gives 8, and a stride of 16 words gives 16.
- R6: `rsp_valid` is high for exactly one cycle. It is sampled high `rsp_cycles + 1` clock edges after the edge that took the request. `rsp_data` and `rsp_cycles` then hold their values until the next request is taken.
- R7: An inactive thread (`req_mask[t]` = 0) returns 0 and adds nothing to `rsp_cycles`. An all-zero mask gives `rsp_cycles` = 0.
- R8: While `rst_n` is low, and on leaving reset, the outputs are `req_ready` = 1, `rsp_valid` = 0, `rsp_cycles` = 0 and `rsp_data` = 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block idle, can take a request |
| req_mask | input | 16 | Active bit per thread |
| req_addr | input | 160 | 16 word addresses of 10 bits, thread t at bits t*10 |
| rsp_valid | output | 1 | One-cycle pulse: response ready |
| rsp_data | output | 512 | 16 read words of 32 bits, thread t at bits t*32 |
| rsp_cycles | output | 5 | Number of bank passes the last request used |

## Verification
Two events can share one clock edge: the block delivers a response (`rsp_valid` high) and takes the next request, because `req_ready` comes back in that same cycle. The bench provokes this by placing a new request on the bus in the cycle of each response. It then checks that the old response is complete and correct in that cycle. It also checks that the new request starts from cleared data and shows its own pass count and latency. Broadcast and conflict can also occur in the same bank during one request. A mixed pattern checks that duplicate words are merged while distinct words are still handled in separate passes.

// File: rtl/scratch_pkg.sv
// Package for the banked scratchpad serializer.
// Holds the control state type and the function that gives the
// start-up contents of the storage.
// Assumes that word addresses fit in 32 bits.
package scratch_pkg;

    typedef enum logic [1:0] {
        SRV_IDLE  = 2'd0,
        SRV_BUSY  = 2'd1,
        SRV_DRAIN = 2'd2
    } srv_state_e;

    // Start-up contents of the word at global address a.
    function automatic logic [31:0] seed_word(input logic [31:0] a);
        logic [31:0] prod;
        prod = a * 32'h9E3779B1;
        return prod ^ 32'h5A5A0000;
    endfunction

endpackage

// File: rtl/scratch_bank_pick.sv
// Per-bank selector.
// Among the pending threads that map to bank BANK_ID, it finds the
// lowest-numbered one. It takes that thread's word as the word this
// bank reads in the current pass, and marks every pending thread that
// wants the same word as served.
// Assumes bank = low BANK_BITS bits of the word address.
module scratch_bank_pick #(
    parameter int NUM_THREADS = 16,
    parameter int ADDR_W      = 10,
    parameter int BANK_BITS   = 4,
    parameter int BANK_ID     = 0,
    localparam int ROW_W      = ADDR_W - BANK_BITS
) (
    input  logic [NUM_THREADS-1:0]             pending,
    input  logic [NUM_THREADS-1:0][ADDR_W-1:0] addr,
    output logic                               rd_en,
    output logic [ROW_W-1:0]                   rd_row,
    output logic [NUM_THREADS-1:0]             serve
);

    localparam logic [BANK_BITS-1:0] MY_BANK = BANK_BITS'(BANK_ID);

    logic              found;
    logic [ADDR_W-1:0] lead;

    // Find the word of the lowest-numbered pending thread in this bank.
    always_comb begin
        found = 1'b0;
        lead  = '0;
        for (int t = 0; t < NUM_THREADS; t++) begin
            if (!found && pending[t] && addr[t][BANK_BITS-1:0] == MY_BANK) begin
                found = 1'b1;
                lead  = addr[t];
            end
        end
    end

    // Serve every pending thread that wants the chosen word (broadcast).
    always_comb begin
        for (int t = 0; t < NUM_THREADS; t++) begin
            serve[t] = found && pending[t] && (addr[t] == lead);
        end
    end

    assign rd_en  = found;
    assign rd_row = lead[ADDR_W-1:BANK_BITS];

endmodule

// File: rtl/scratch_bank_ram.sv
// Storage of one bank: a synchronous read RAM with one cycle of latency.
// At start-up it is loaded with seed_word() of each word's global address,
// which is row * NUM_BANKS + BANK_ID.
// Assumes read-only use. The output holds its value when rd_en is low.
module scratch_bank_ram #(
    parameter int DATA_W    = 32,
    parameter int ROW_W     = 6,
    parameter int NUM_BANKS = 16,
    parameter int BANK_ID   = 0,
    localparam int ROWS     = 1 << ROW_W
) (
    input  logic              clk,
    input  logic              rd_en,
    input  logic [ROW_W-1:0]  rd_row,
    output logic [DATA_W-1:0] rd_data
);

    logic [DATA_W-1:0] mem [ROWS];

    // Load the start-up pattern.
    initial begin
        for (int r = 0; r < ROWS; r++) begin
            mem[r] = DATA_W'(scratch_pkg::seed_word(32'(r * NUM_BANKS + BANK_ID)));
        end
    end

    // Registered read port.
    always_ff @(posedge clk) begin
        if (rd_en) rd_data <= mem[rd_row];
    end

endmodule

// File: rtl/scratch_conflict_serializer.sv
// Top of the banked scratchpad serializer.
// It takes one request of NUM_THREADS word addresses plus an active mask.
// Each pass, it lets every bank read the word of its lowest pending
// thread and marks all threads that want that word as served. It repeats
// until no thread is waiting. One cycle later, it returns the gathered
// words together with the number of passes used.
// Assumes that the banks are read only and that the RAM latency is one cycle.
module scratch_conflict_serializer #(
    parameter int NUM_THREADS = 16,
    parameter int NUM_BANKS   = 16,
    parameter int DATA_W      = 32,
    parameter int ADDR_W      = 10,
    localparam int CYC_W      = $clog2(NUM_THREADS + 1)
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          req_valid,
    output logic                          req_ready,
    input  logic [NUM_THREADS-1:0]        req_mask,
    input  logic [NUM_THREADS*ADDR_W-1:0] req_addr,
    output logic                          rsp_valid,
    output logic [NUM_THREADS*DATA_W-1:0] rsp_data,
    output logic [CYC_W-1:0]              rsp_cycles
);
    import scratch_pkg::*;

    localparam int BANK_BITS = $clog2(NUM_BANKS);
    localparam int ROW_W     = ADDR_W - BANK_BITS;

    srv_state_e                            state;
    logic [NUM_THREADS-1:0]                pending;
    logic [NUM_THREADS-1:0]                capt;
    logic [NUM_THREADS-1:0][ADDR_W-1:0]    addr_in;
    logic [NUM_THREADS-1:0][ADDR_W-1:0]    addr_q;
    logic [NUM_THREADS-1:0][DATA_W-1:0]    data_q;
    logic [NUM_BANKS-1:0][NUM_THREADS-1:0] serve_b;
    logic [NUM_THREADS-1:0]                serve_all;
    logic [NUM_BANKS-1:0][DATA_W-1:0]      ram_q;
    logic [CYC_W-1:0]                      cyc_q;
    logic                                  accept;

    assign accept    = req_valid && (state == SRV_IDLE);
    assign req_ready = (state == SRV_IDLE);

    // Split the flat address bus into one address per thread.
    always_comb begin
        for (int t = 0; t < NUM_THREADS; t++) begin
            addr_in[t] = req_addr[t*ADDR_W +: ADDR_W];
        end
    end

    // One selector and one RAM per bank.
    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        logic             rd_en;
        logic [ROW_W-1:0] rd_row;

        scratch_bank_pick #(
            .NUM_THREADS (NUM_THREADS),
            .ADDR_W      (ADDR_W),
            .BANK_BITS   (BANK_BITS),
            .BANK_ID     (b)
        ) u_pick (
            .pending (pending),
            .addr    (addr_q),
            .rd_en   (rd_en),
            .rd_row  (rd_row),
            .serve   (serve_b[b])
        );

        scratch_bank_ram #(
            .DATA_W    (DATA_W),
            .ROW_W     (ROW_W),
            .NUM_BANKS (NUM_BANKS),
            .BANK_ID   (b)
        ) u_ram (
            .clk     (clk),
            .rd_en   (rd_en),
            .rd_row  (rd_row),
            .rd_data (ram_q[b])
        );
    end

    // Merge the per-bank served masks (each thread lies in one bank).
    always_comb begin
        serve_all = '0;
        for (int b = 0; b < NUM_BANKS; b++) begin
            serve_all = serve_all | serve_b[b];
        end
    end

    // Control: take a request, run passes until none pending, then drain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= SRV_IDLE;
            pending   <= '0;
            capt      <= '0;
            addr_q    <= '0;
            cyc_q     <= '0;
            rsp_valid <= 1'b0;
        end else begin
            rsp_valid <= 1'b0;
            capt      <= '0;
            case (state)
                SRV_IDLE: begin
                    if (accept) begin
                        addr_q  <= addr_in;
                        pending <= req_mask;
                        cyc_q   <= '0;
                        state   <= (req_mask == '0) ? SRV_DRAIN : SRV_BUSY;
                    end
                end
                SRV_BUSY: begin
                    pending <= pending & ~serve_all;
                    capt    <= serve_all;
                    cyc_q   <= cyc_q + 1'b1;
                    if ((pending & ~serve_all) == '0) state <= SRV_DRAIN;
                end
                SRV_DRAIN: begin
                    rsp_valid <= 1'b1;
                    state     <= SRV_IDLE;
                end
                default: state <= SRV_IDLE;
            endcase
        end
    end

    // Data: clear on accept, then capture each thread's bank output one cycle after its pass.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            data_q <= '0;
        end else if (accept) begin
            data_q <= '0;
        end else begin
            for (int t = 0; t < NUM_THREADS; t++) begin
                if (capt[t]) data_q[t] <= ram_q[addr_q[t][BANK_BITS-1:0]];
            end
        end
    end

    // Flatten the per-thread data onto the response bus.
    always_comb begin
        for (int t = 0; t < NUM_THREADS; t++) begin
            rsp_data[t*DATA_W +: DATA_W] = data_q[t];
        end
    end

    assign rsp_cycles = cyc_q;

endmodule

// File: rtl/scratch_serializer_chk.sv
// Checker for the serializer's handshake, latency and pass-count rules.
// It watches the ports only. It keeps a copy of the accepted mask and a
// count of the edges since the request was taken.
// Assumes a single request in flight, which the handshake ensures.
module scratch_serializer_chk #(
    parameter int NUM_THREADS = 16,
    parameter int CYC_W       = 5
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic                   req_valid,
    input logic                   req_ready,
    input logic [NUM_THREADS-1:0] req_mask,
    input logic                   rsp_valid,
    input logic [CYC_W-1:0]       rsp_cycles
);

    logic                   busy;
    logic [CYC_W:0]         lat_cnt;
    logic [NUM_THREADS-1:0] mask_q;

    // Track the request in flight and the edges since it was taken.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy    <= 1'b0;
            lat_cnt <= '0;
            mask_q  <= '0;
        end else if (req_valid && req_ready) begin
            busy    <= 1'b1;
            lat_cnt <= '0;
            mask_q  <= req_mask;
        end else if (busy) begin
            lat_cnt <= lat_cnt + 1'b1;
            if (rsp_valid) busy <= 1'b0;
        end
    end

    p_ready_drops_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> !req_ready);

    p_ready_with_rsp_r2: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> req_ready);

    p_latency_r6: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> (busy && lat_cnt == {1'b0, rsp_cycles} + 1'b1));

    p_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid);

    p_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (req_ready && !req_valid) |=> $stable(rsp_cycles));

    p_cycles_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> (32'(rsp_cycles) <= 32'($countones(mask_q))));

    p_empty_mask_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && mask_q == '0) |-> rsp_cycles == '0);

    p_active_mask_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && mask_q != '0) |-> rsp_cycles != '0);

endmodule

bind scratch_conflict_serializer scratch_serializer_chk #(
    .NUM_THREADS (NUM_THREADS),
    .CYC_W       (CYC_W)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .req_ready  (req_ready),
    .req_mask   (req_mask),
    .rsp_valid  (rsp_valid),
    .rsp_cycles (rsp_cycles)
);

// File: tb/scratch_conflict_serializer_tb.sv
module scratch_conflict_serializer_tb;
    localparam int CLK_PERIOD = 10;
    localparam int NT = 16;
    localparam int NB = 16;
    localparam int DW = 32;
    localparam int AW = 10;
    localparam int CW = 5;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             req_valid = 1'b0;
    logic             req_ready;
    logic [NT-1:0]    req_mask = '0;
    logic [NT*AW-1:0] req_addr = '0;
    logic             rsp_valid;
    logic [NT*DW-1:0] rsp_data;
    logic [CW-1:0]    rsp_cycles;

    int n_run = 0;
    int n_fail = 0;

    // Expected values of the request in flight.
    int          exp_n;
    logic [31:0] exp_data [NT];

    always #(CLK_PERIOD/2) clk = ~clk;

    scratch_conflict_serializer u_dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_mask(req_mask), .req_addr(req_addr), .rsp_valid(rsp_valid),
        .rsp_data(rsp_data), .rsp_cycles(rsp_cycles)
    );

    task automatic summary();
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    endtask

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    function automatic logic [31:0] ref_word(input int a);
        logic [31:0] m;
        m = 32'(a) * 32'h9E3779B1;
        return m ^ 32'h5A5A0000;
    endfunction

    // Put a request on the bus and work out its expected pass count and data.
    task automatic drive(input logic [NT-1:0] m, input int a [NT]);
        exp_n = 0;
        for (int b = 0; b < NB; b++) begin
            int words[$];
            words = {};
            for (int t = 0; t < NT; t++) begin
                if (m[t] && (a[t] % NB) == b) begin
                    bit seen = 0;
                    foreach (words[i]) if (words[i] == a[t]) seen = 1;
                    if (!seen) words.push_back(a[t]);
                end
            end
            if (words.size() > exp_n) exp_n = words.size();
        end
        for (int t = 0; t < NT; t++) begin
            exp_data[t] = m[t] ? ref_word(a[t]) : 32'h0;
            req_addr[t*AW +: AW] = AW'(a[t]);
        end
        req_mask  = m;
        req_valid = 1'b1;
    endtask

    // Called at a negedge with a request on the bus: follow it each cycle to its response.
    task automatic collect(input string req, input bit chain);
        chk(req_ready == 1'b1, "R2", "ready before accept", 32'(req_ready), 32'h1);
        @(negedge clk);
        req_valid = 1'b0;
        for (int k = 1; k <= exp_n + 1; k++) begin
            @(negedge clk);
            chk(rsp_valid == (k == exp_n + 1), "R6", "rsp_valid timing", 32'(rsp_valid), 32'(k == exp_n + 1));
            chk(req_ready == (k == exp_n + 1), "R2", "ready while busy", 32'(req_ready), 32'(k == exp_n + 1));
            if (rsp_valid) break;
        end
        chk(32'(rsp_cycles) == 32'(exp_n), req, "rsp_cycles", 32'(rsp_cycles), 32'(exp_n));
        for (int t = 0; t < NT; t++) begin
            chk(rsp_data[t*DW +: DW] == exp_data[t], "R1", "data word", rsp_data[t*DW +: DW], exp_data[t]);
        end
        if (!chain) begin
            @(negedge clk);
            chk(rsp_valid == 1'b0, "R6", "pulse ends", 32'(rsp_valid), 32'h0);
            chk(32'(rsp_cycles) == 32'(exp_n), "R6", "cycles held", 32'(rsp_cycles), 32'(exp_n));
            chk(rsp_data[DW-1:0] == exp_data[0], "R6", "data held", rsp_data[DW-1:0], exp_data[0]);
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL R2 watchdog: actual no response expected response");
        summary();
    end

    initial begin
        int a [NT];
        void'($urandom(32'd11));
        // R8: outputs in reset
        repeat (2) @(negedge clk);
        chk(req_ready == 1'b1, "R8", "ready in reset", 32'(req_ready), 32'h1);
        chk(rsp_valid == 1'b0, "R8", "rsp_valid in reset", 32'(rsp_valid), 32'h0);
        chk(rsp_cycles == '0, "R8", "cycles in reset", 32'(rsp_cycles), 32'h0);
        chk(rsp_data == '0, "R8", "data in reset", rsp_data[31:0], 32'h0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(req_ready == 1'b1 && rsp_valid == 1'b0, "R8", "after reset", 32'(rsp_valid), 32'h0);

        // R3: stride 1, all banks distinct
        for (int t = 0; t < NT; t++) a[t] = 100 + t;
        drive('1, a); collect("R3", 0);
        // R4: all threads read one word
        for (int t = 0; t < NT; t++) a[t] = 37;
        drive('1, a); collect("R4", 0);
        // R5: stride 2 gives 2 passes
        for (int t = 0; t < NT; t++) a[t] = 2 * t;
        drive('1, a); collect("R5", 0);
        // R5: stride 8 gives 8 passes
        for (int t = 0; t < NT; t++) a[t] = 8 * t + 3;
        drive('1, a); collect("R5", 0);
        // R5: stride 16, all in one bank
        for (int t = 0; t < NT; t++) a[t] = 16 * t + 5;
        drive('1, a); collect("R5", 0);
        // R4/R5: broadcast and conflict mixed in one bank
        for (int t = 0; t < NT; t++) a[t] = (t < 8) ? 5 : 5 + 16 * (t - 8);
        drive('1, a); collect("R4", 0);
        // R7: half mask on a 16-way pattern gives 8, inactive threads return zero
        for (int t = 0; t < NT; t++) a[t] = 16 * t + 9;
        drive(16'h00FF, a); collect("R7", 0);
        // R7: empty mask
        drive(16'h0000, a); collect("R7", 0);
        // R2/R6: next request taken in the response cycle
        for (int t = 0; t < NT; t++) a[t] = 4 * t;
        drive('1, a); collect("R5", 1);
        for (int t = 0; t < NT; t++) a[t] = 700 + t;
        drive(16'hA5A5, a); collect("R3", 1);
        for (int t = 0; t < NT; t++) a[t] = 3;
        drive(16'h0F0F, a); collect("R4", 0);
        // R1/R5: random patterns
        for (int i = 0; i < 40; i++) begin
            for (int t = 0; t < NT; t++) a[t] = (i % 2 == 0) ? int'($urandom_range(63)) : int'($urandom_range(1023));
            drive(16'($urandom), a); collect("R5", i % 3 == 0);
        end
        @(negedge clk);
        summary();
    end
endmodule